// File: doc/BRIEF.md
# Pull-Enable to Ready/Valid Symbol Stream Adapter

This block sits between an upstream symbol source that is read through an enable pin and a downstream consumer that uses ordinary valid/ready flow control. The source answers an enable one clock later. When the enable is low, it keeps its valid flag and data unchanged. The adapter drives that enable and keeps a registered copy of it. It counts an incoming symbol only when the source's valid flag is high and the enable was high in the cycle before.

Each symbol carries three flags: start of packet, end of packet, and an erasure marker. Every accepted symbol goes into a small skid buffer, which offers it downstream with valid/ready rules. The enable is dropped early enough that a symbol still in flight always finds a free slot. A framing monitor raises a one-cycle error pulse when a start flag arrives inside an open packet, or when an end flag arrives with no packet open.

Top module: `esa_stream_adapter`

## Requirements
- R1: While `rst` is high, `up_rd_en` is 0. In the cycle after `rst` falls, `dn_vld` and `framing_err` are both 0.
- R2: A symbol is taken in at a clock edge only when `up_vld` is high and `up_rd_en` was high during the cycle before that edge. A valid symbol that the source holds while the enable is low is not taken in a second time.
- R3: Accepted symbols leave on the `dn_*` ports in arrival order. `dn_sym`, `dn_first`, `dn_last` and `dn_erase` each equal the value that was received for that symbol.
- R4: While the downstream side stalls, the block requests at most DEPTH symbols and then holds `up_rd_en` at 0, and no symbol is lost. DEPTH defaults to 4.
- R5: While `dn_vld` is 1 and `dn_rdy` is 0, at the next edge `dn_vld` stays 1 and all four output fields stay unchanged.
- R6: An accepted symbol with the start flag set while a packet is open gives `framing_err` = 1 for exactly the cycle after it is accepted.
- R7: An accepted symbol with the end flag set and the start flag clear, while no packet is open, gives a `framing_err` pulse in the cycle after it is accepted.
- R8: Well-formed packets, including a packet of one symbol with both flags set, never raise `framing_err`.
- R9: Reset empties the skid buffer and closes any open packet. After reset, a start flag gives no error and a lone end flag gives an error.
- R10: In a cycle where `up_vld` is low, or where no enable was issued in the cycle before, the values on `up_sym`, `up_first`, `up_last` and `up_erase` have no effect on the outputs or on `framing_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_rd_en | output | 1 | Read request to the upstream source |
| up_vld | input | 1 | Upstream symbol valid |
| up_sym | input | SYM_W | Upstream symbol |
| up_first | input | 1 | Upstream start-of-packet flag |
| up_last | input | 1 | Upstream end-of-packet flag |
| up_erase | input | 1 | Upstream erasure marker |
| dn_vld | output | 1 | Downstream symbol valid |
| dn_rdy | input | 1 | Downstream ready |
| dn_sym | output | SYM_W | Downstream symbol |
| dn_first | output | 1 | Downstream start-of-packet flag |
| dn_last | output | 1 | Downstream end-of-packet flag |
| dn_erase | output | 1 | Downstream erasure marker |
| framing_err | output | 1 | One-cycle packet framing error pulse |

## Verification
The first pattern is a steady source with `dn_rdy` always high. It shows that symbols pass in order at full rate and that clean packets raise no error. The second pattern has random source gaps, random ready, and random garbage on the data lines while valid is low. It separates real captures from stale or held values, and a single duplicate or drop shows up at once. A long downstream stall with a full source measures how many symbols the block requests before it drops the enable, and confirms that the outputs are held. Directed framing faults, plus a reset in the middle of a packet, tell the two error conditions apart and show that reset clears the packet state.

// File: rtl/esa_pkg.sv
package esa_pkg;

   typedef enum logic {
      PKT_IDLE = 1'b0,
      PKT_OPEN = 1'b1
   } esa_pkt_state_e;

   typedef struct packed {
      logic first;
      logic last;
      logic erase;
   } esa_flags_t;

   localparam int ESA_FLAG_W = $bits(esa_flags_t);

endpackage

// File: rtl/esa_pull_ctrl.sv
module esa_pull_ctrl #(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] fill,
   input  logic          up_vld,
   output logic          rd_en,
   output logic          rd_en_q,
   output logic          accept
);

   // slots already committed: stored plus the one that may land this cycle
   logic [CW:0] committed;

   assign committed = {1'b0, fill} + {{CW{1'b0}}, rd_en_q};
   assign rd_en     = !rst && (committed < (CW+1)'(DEPTH));
   assign accept    = up_vld && rd_en_q;

   always_ff @(posedge clk) begin
      if (rst) rd_en_q <= 1'b0;
      else     rd_en_q <= rd_en;
   end

endmodule

// File: rtl/esa_skid_fifo.sv
module esa_skid_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] fill,
   output logic          nonempty
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign nonempty = (fill != '0);
   assign dout     = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

endmodule

// File: rtl/esa_frame_chk.sv
module esa_frame_chk
   import esa_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic accept,
   input  logic first,
   input  logic last,
   output logic err,
   output logic open
);

   esa_pkt_state_e st;
   logic           dup_start, orphan_end;

   assign open       = (st == PKT_OPEN);
   assign dup_start  = first && open;
   assign orphan_end = last && !first && !open;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= PKT_IDLE;
         err <= 1'b0;
      end else begin
         err <= accept && (dup_start || orphan_end);
         if (accept) begin
            if (last)       st <= PKT_IDLE;
            else if (first) st <= PKT_OPEN;
         end
      end
   end

endmodule

// File: rtl/esa_stream_adapter.sv
module esa_stream_adapter
   import esa_pkg::*;
#(
   parameter int SYM_W    = 8,
   parameter int DEPTH    = 4,
   parameter bit ERASE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   output logic             up_rd_en,
   input  logic             up_vld,
   input  logic [SYM_W-1:0] up_sym,
   input  logic             up_first,
   input  logic             up_last,
   input  logic             up_erase,
   output logic             dn_vld,
   input  logic             dn_rdy,
   output logic [SYM_W-1:0] dn_sym,
   output logic             dn_first,
   output logic             dn_last,
   output logic             dn_erase,
   output logic             framing_err
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int PW = SYM_W + ESA_FLAG_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("esa_stream_adapter: DEPTH must be at least 2");
      end
      if (SYM_W < 1) begin : g_bad_width
         $error("esa_stream_adapter: SYM_W must be at least 1");
      end
   endgenerate

   logic          rd_en_q, accept, pop, pkt_open;
   logic [CW-1:0] fill;
   logic [PW-1:0] din, dout;
   logic          erase_in;
   esa_flags_t    in_fl, out_fl;

   generate
      if (ERASE_EN) begin : g_erase
         assign erase_in = up_erase;
      end else begin : g_no_erase
         assign erase_in = 1'b0;
      end
   endgenerate

   assign in_fl = '{first: up_first, last: up_last, erase: erase_in};
   assign din   = {in_fl, up_sym};
   assign pop   = dn_vld && dn_rdy;

   esa_pull_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .fill    (fill),
      .up_vld  (up_vld),
      .rd_en   (up_rd_en),
      .rd_en_q (rd_en_q),
      .accept  (accept)
   );

   esa_skid_fifo #(.W(PW), .DEPTH(DEPTH), .CW(CW)) fifo_i (
      .clk      (clk),
      .rst      (rst),
      .push     (accept),
      .din      (din),
      .pop      (pop),
      .dout     (dout),
      .fill     (fill),
      .nonempty (dn_vld)
   );

   esa_frame_chk frame_i (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .first  (up_first),
      .last   (up_last),
      .err    (framing_err),
      .open   (pkt_open)
   );

   assign {out_fl, dn_sym} = dout;
   assign dn_first = out_fl.first;
   assign dn_last  = out_fl.last;
   assign dn_erase = out_fl.erase;

endmodule

// File: rtl/esa_adapter_chk.sv
module esa_adapter_chk #(
   parameter int SYM_W = 8,
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             up_rd_en,
   input logic             accept,
   input logic             pop,
   input logic [CW-1:0]    fill,
   input logic             dn_vld,
   input logic             dn_rdy,
   input logic [SYM_W-1:0] dn_sym,
   input logic             dn_first,
   input logic             dn_last,
   input logic             dn_erase,
   input logic             framing_err,
   input logic             up_first,
   input logic             up_last,
   input logic             pkt_open
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !dn_vld && !framing_err);

   p_accept_after_en_r2: assert property (@(posedge clk) disable iff (rst)
      accept |-> $past(up_rd_en));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
      accept && !pop |-> fill < CW'(DEPTH));

   p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
      dn_vld && !dn_rdy |=> dn_vld && $stable(dn_sym) && $stable(dn_first)
                            && $stable(dn_last) && $stable(dn_erase));

   p_dup_start_r6: assert property (@(posedge clk) disable iff (rst)
      accept && up_first && pkt_open |=> framing_err);

   p_orphan_end_r7: assert property (@(posedge clk) disable iff (rst)
      accept && up_last && !up_first && !pkt_open |=> framing_err);

   p_clean_start_r8: assert property (@(posedge clk) disable iff (rst)
      accept && up_first && !pkt_open |=> !framing_err);

   p_no_spurious_err_r10: assert property (@(posedge clk) disable iff (rst)
      !accept |=> !framing_err);

endmodule

bind esa_stream_adapter esa_adapter_chk #(.SYM_W(SYM_W), .DEPTH(DEPTH), .CW(CW)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .up_rd_en    (up_rd_en),
   .accept      (accept),
   .pop         (pop),
   .fill        (fill),
   .dn_vld      (dn_vld),
   .dn_rdy      (dn_rdy),
   .dn_sym      (dn_sym),
   .dn_first    (dn_first),
   .dn_last     (dn_last),
   .dn_erase    (dn_erase),
   .framing_err (framing_err),
   .up_first    (up_first),
   .up_last     (up_last),
   .pkt_open    (pkt_open)
);

// File: tb/esa_stream_adapter_tb_top.sv
`timescale 1ns/1ps
module esa_stream_adapter_tb_top;

   localparam int SYM_W = 8;
   localparam int DEPTH = 4;

   typedef struct packed {
      logic [SYM_W-1:0] sym;
      logic             f;
      logic             l;
      logic             e;
   } item_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             up_rd_en, up_vld, up_first, up_last, up_erase;
   logic [SYM_W-1:0] up_sym, dn_sym;
   logic             dn_vld, dn_rdy, dn_first, dn_last, dn_erase, framing_err;

   always #2.5 clk = ~clk;

   esa_stream_adapter #(.SYM_W(SYM_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst(rst), .up_rd_en(up_rd_en), .up_vld(up_vld),
      .up_sym(up_sym), .up_first(up_first), .up_last(up_last),
      .up_erase(up_erase), .dn_vld(dn_vld), .dn_rdy(dn_rdy),
      .dn_sym(dn_sym), .dn_first(dn_first), .dn_last(dn_last),
      .dn_erase(dn_erase), .framing_err(framing_err)
   );

   item_t src_q[$];
   item_t exp_q[$];
   int    n_chk = 0, n_bad = 0;
   int    gap_pct = 0;
   int    rdy_mode = 0;   // 0 always ready, 1 random, 2 never
   int    emitted = 0;
   int    err_exp = 0, err_seen = 0;
   bit    open_m = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic send(input logic [SYM_W-1:0] s, input logic f, input logic l, input logic e);
      item_t it;
      it.sym = s; it.f = f; it.l = l; it.e = e;
      src_q.push_back(it);
   endtask

   task automatic send_pkt(input int len, input logic [SYM_W-1:0] base);
      for (int i = 0; i < len; i++)
         send(base + SYM_W'(i), i == 0, i == len - 1, 1'(i % 3 == 1));
   endtask

   task automatic drain();
      while (src_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   // upstream source model: answers the enable one cycle later, holds otherwise
   initial begin
      bit    en_s;
      item_t it;
      up_vld = 0; up_sym = '0; up_first = 0; up_last = 0; up_erase = 0;
      forever begin
         @(negedge clk);
         en_s = up_rd_en;
         @(posedge clk);
         #1;
         if (en_s) begin
            if (src_q.size() != 0 && int'($urandom % 100) >= gap_pct) begin
               it = src_q.pop_front();
               up_vld = 1; up_sym = it.sym; up_first = it.f;
               up_last = it.l; up_erase = it.e;
               exp_q.push_back(it);
               emitted++;
               if (it.f && open_m) err_exp++;
               else if (it.l && !it.f && !open_m) err_exp++;
               open_m = it.l ? 1'b0 : (it.f ? 1'b1 : open_m);
            end else begin
               // R10: garbage on the data lines while valid is low
               up_vld = 0; up_sym = SYM_W'($urandom);
               up_first = 1'($urandom); up_last = 1'($urandom); up_erase = 1'($urandom);
            end
         end
      end
   end

   // downstream monitor and scoreboard
   initial begin
      bit    hold_pend = 0;
      item_t held, got, want;
      dn_rdy = 1;
      forever begin
         @(negedge clk);
         if (rst) begin
            hold_pend = 0;
         end else begin
            case (rdy_mode)
               0:       dn_rdy = 1;
               1:       dn_rdy = 1'($urandom);
               default: dn_rdy = 0;
            endcase
            got.sym = dn_sym; got.f = dn_first; got.l = dn_last; got.e = dn_erase;
            if (hold_pend)  // R5
               chk(dn_vld && got == held, "R5 output held during stall",
                   int'({dn_vld, got}), int'({1'b1, held}));
            if (dn_vld && dn_rdy) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R2 unexpected extra symbol", int'(got), -1);
               end else begin
                  want = exp_q.pop_front();
                  chk(got == want, "R3 symbol and flags in order", int'(got), int'(want));
               end
            end
            hold_pend = dn_vld && !dn_rdy;
            held = got;
            if (framing_err) err_seen++;
         end
      end
   end

   // watchdog
   initial begin
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset behaviour
      repeat (3) @(negedge clk);
      chk(up_rd_en == 0, "R1 enable low in reset", up_rd_en, 0);
      @(posedge clk); #1 rst = 0;
      @(negedge clk);
      chk(dn_vld == 0 && framing_err == 0, "R1 quiet after reset",
          int'({dn_vld, framing_err}), 0);

      // R3 R8: steady stream, clean packets incl. single-symbol packet
      for (int p = 0; p < 6; p++) send_pkt(p + 1, SYM_W'(p * 16));
      drain();
      chk(err_seen == err_exp, "R8 no error on clean packets", err_seen, err_exp);

      // R2 R10: gaps, random ready, garbage while invalid
      gap_pct = 40; rdy_mode = 1;
      for (int p = 0; p < 20; p++) send_pkt(2 + p % 5, SYM_W'($urandom));
      drain();
      chk(err_seen == err_exp, "R10 invalid cycles leave framing untouched", err_seen, err_exp);
      chk(exp_q.size() == 0, "R2 no missing symbol", exp_q.size(), 0);

      // R4 R5: long stall with full source
      gap_pct = 0; rdy_mode = 2;
      repeat (2) @(negedge clk);
      emitted = 0;
      send_pkt(10, 8'h40);
      repeat (40) @(negedge clk);
      chk(emitted == DEPTH, "R4 requests limited to depth", emitted, DEPTH);
      chk(up_rd_en == 0, "R4 enable dropped when full", up_rd_en, 0);
      chk(dn_vld == 1, "R5 valid held while stalled", dn_vld, 1);
      rdy_mode = 1;
      drain();
      chk(err_seen == err_exp, "R4 stalled packet intact", err_seen, err_exp);

      // R6: start inside open packet
      rdy_mode = 0;
      send(8'h01, 1, 0, 0); send(8'h02, 0, 0, 1); send(8'h03, 1, 0, 0); send(8'h04, 0, 1, 0);
      drain();
      chk(err_exp == err_seen && err_seen > 0, "R6 duplicate start flagged", err_seen, err_exp);
      // R7: end with no packet open
      send(8'h05, 0, 1, 0);
      drain();
      chk(err_exp == err_seen, "R7 orphan end flagged", err_seen, err_exp);

      // R9: reset with buffered data and an open packet
      rdy_mode = 2;
      send(8'h10, 1, 0, 0); send(8'h11, 0, 0, 0);
      repeat (12) @(negedge clk);
      @(posedge clk); #1 rst = 1;
      repeat (2) @(negedge clk);
      exp_q.delete();
      open_m = 0;
      chk(up_rd_en == 0, "R1 enable low in second reset", up_rd_en, 0);
      @(posedge clk); #1 rst = 0;
      rdy_mode = 0;
      @(negedge clk);
      chk(dn_vld == 0, "R9 buffer emptied by reset", dn_vld, 0);
      send(8'h20, 1, 0, 0); send(8'h21, 0, 1, 0);
      drain();
      chk(err_seen == err_exp, "R9 start after reset is clean", err_seen, err_exp);
      send(8'h22, 0, 1, 1);
      drain();
      chk(err_seen == err_exp, "R9 lone end after reset flagged", err_seen, err_exp);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule